// File: doc/BRIEF.md
# I2S Clock Generator and Pin Router

This block makes the master clock, bit clock and word-select timing for both directions of an I2S audio port and routes them to the pins. Each direction has a fractional rate divider, described by an 8-bit numerator and an 8-bit denominator. It is fed by a source-clock strobe that is taken either from the peripheral clock or from the audio PLL. The divided master clock then goes through an integer bit-rate divider, which makes the serial bit clock (SCK) and the word-select (WS) signal. The whole block runs on one system clock. Both source clocks arrive as single-cycle enable strobes in that domain.

Per-direction mode fields do four things. They pick the master-clock source. They let one direction borrow the other direction's bit clock and word select, so transmit and receive can share a clock pair. They drive the master-clock pin enable. They select master or slave operation for the SCK and WS pins. In slave mode the SCK and WS used inside the block are taken from the pins. The serial shifter, the FIFOs and the PLL are outside this block. Configuration arrives through a plain one-cycle write port.

All pin and clock signals are plain level signals, and no data stream crosses the block boundary. For that reason the block has no valid/ready interface and applies no back-pressure. Index 0 of every two-bit port is the transmit direction and index 1 is the receive direction.

Top module: `i2s_clkgen`

## Requirements
- R1: After reset, both directions are in slave mode (control bit 5 = 1), every rate, bit-rate and mode field is zero, and `mclk_o`, `mclk_oe`, `sck_oe` and `ws_oe` are all low.
- R2: The rate word sits at address 4 (transmit) or 5 (receive). Bits 15:8 hold the numerator X and bits 7:0 hold the denominator Y. Each source strobe adds X to an accumulator. When the sum reaches Y or more, Y is subtracted and the divider output toggles. Over T strobes after a reload, the output toggles floor(T·X/Y) times.
- R3: When X is 0, or X is greater than Y, the divider output is held low.
- R4: Bit 0 at address 8 selects the source strobe for both dividers: 0 selects `pclk_tick` and 1 selects `pll_tick`.
- R5: Mode bits 1:0 (address 2 or 3) choose that direction's master clock. 00 selects its own divider. 01 selects the other direction's divider. 10 selects the `mclk_i` pin. 11 holds the master clock low.
- R6: A bit-rate value N (bits 5:0 at address 6 or 7) makes SCK toggle once every N+1 master-clock edges, counting both rising and falling edges. SCK therefore equals the master clock divided by N+1, for N from 0 to 63.
- R7: WS toggles once every 16 SCK periods and changes only on a falling edge of SCK.
- R8: Mode bit 2 set makes that direction's SCK and WS pin outputs come from the other direction's bit-clock generator.
- R9: Control bit 5 (address 0 or 1) set to 1 selects slave. In slave mode `sck_oe` and `ws_oe` are low and `sck_int`/`ws_int` follow `sck_i`/`ws_i`. With the bit at 0, both enables are high and `sck_int`/`ws_int` follow the generated signals.
- R10: Mode bit 3 drives that direction's `mclk_oe`.
- R11: A rate write clears the accumulator and the divider output at the write edge. With X=1 and Y=5 and a strobe every cycle, the output first rises 5 cycles after the write edge. A bit-rate write clears SCK and WS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk_tick | input | 1 | Peripheral-clock source strobe |
| pll_tick | input | 1 | Audio-PLL source strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| mclk_i | input | 2 | Master-clock pin inputs |
| sck_i | input | 2 | SCK pin inputs (slave) |
| ws_i | input | 2 | WS pin inputs (slave) |
| mclk_o | output | 2 | Master-clock pin outputs |
| mclk_oe | output | 2 | Master-clock pin enables |
| sck_o | output | 2 | SCK pin outputs |
| sck_oe | output | 2 | SCK pin enables |
| ws_o | output | 2 | WS pin outputs |
| ws_oe | output | 2 | WS pin enables |
| sck_int | output | 2 | SCK delivered to the serial logic |
| ws_int | output | 2 | WS delivered to the serial logic |

## Verification
Some properties are checked by assertions on every cycle:
- the accumulator stays below the denominator;
- the master clock stays low while the ratio is invalid or the source code is 11;
- the bit counter never passes its limit;
- SCK moves only on a master-clock edge, and WS moves only on an SCK fall;
- a borrowing master follows the other direction's pins.

Only the bench scenarios can show the rest:
- the actual periods, toggle counts and source selection;
- the exact delay from a rate reload to the first master-clock edge;
- the slave pin paths and the pin-enable levels.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;

  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned SLAVE_BIT = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;  // +dir
  localparam logic [ADDR_W-1:0] A_MODE = 4'd2;  // +dir
  localparam logic [ADDR_W-1:0] A_RATE = 4'd4;  // +dir
  localparam logic [ADDR_W-1:0] A_BITS = 4'd6;  // +dir
  localparam logic [ADDR_W-1:0] A_SRC  = 4'd8;

  typedef enum logic [1:0] {
    MSRC_OWN   = 2'b00,
    MSRC_OTHER = 2'b01,
    MSRC_PIN   = 2'b10,
    MSRC_OFF   = 2'b11
  } msrc_e;

  typedef struct packed {
    logic  mclk_oe;  // bit 3
    logic  share;    // bit 2
    msrc_e msrc;     // bits 1:0
  } mode_t;

  function automatic logic [ADDR_W-1:0] dir_addr(logic [ADDR_W-1:0] base, int dir);
    return base + ADDR_W'(dir);
  endfunction

endpackage

// File: rtl/i2s_clk_regs.sv
module i2s_clk_regs
  import i2s_clkgen_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BR_W   = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [1:0]                    slave,
  output mode_t [1:0]                   mode,
  output logic [1:0][DATA_W-1:0]        rate,
  output logic [1:0][BR_W-1:0]          brate,
  output logic                          src_pll,
  output logic [1:0]                    rate_load,
  output logic [1:0]                    bits_load
);

  always_comb begin
    for (int d = 0; d < 2; d++) begin
      rate_load[d] = wr_en && (wr_addr == dir_addr(A_RATE, d));
      bits_load[d] = wr_en && (wr_addr == dir_addr(A_BITS, d));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_pll <= 1'b0;
      for (int d = 0; d < 2; d++) begin
        slave[d] <= 1'b1;
        mode[d]  <= '0;
        rate[d]  <= '0;
        brate[d] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == A_SRC) src_pll <= wr_data[0];
      for (int d = 0; d < 2; d++) begin
        if (wr_addr == dir_addr(A_CTRL, d)) slave[d] <= wr_data[SLAVE_BIT];
        if (wr_addr == dir_addr(A_MODE, d)) mode[d]  <= mode_t'(wr_data[3:0]);
        if (rate_load[d])                   rate[d]  <= wr_data;
        if (bits_load[d])                   brate[d] <= wr_data[BR_W-1:0];
      end
    end
  end

endmodule

// File: rtl/i2s_frac_div.sv
module i2s_frac_div #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  output logic              mclk
);

  logic [FRAC_W:0] acc;
  logic [FRAC_W:0] sum;
  logic            cfg_ok;

  assign cfg_ok = (num != '0) && (num <= den);
  assign sum    = acc + {1'b0, num};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      mclk <= 1'b0;
    end else if (load || !cfg_ok) begin
      acc  <= '0;
      mclk <= 1'b0;
    end else if (tick) begin
      if (sum >= {1'b0, den}) begin
        acc  <= sum - {1'b0, den};
        mclk <= ~mclk;
      end else begin
        acc  <= sum;
      end
    end
  end

  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (acc < {1'b0, den}))
    else $error("accumulator reached denominator"); // R2

  AST_MCLK_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |=> !mclk)
    else $error("master clock active with invalid ratio"); // R3

endmodule

// File: rtl/i2s_bit_div.sv
module i2s_bit_div #(
  parameter int unsigned BR_W      = 6,
  parameter int unsigned WORD_BITS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            mclk,
  input  logic [BR_W-1:0] ratio,
  output logic            sck,
  output logic            ws
);

  localparam int unsigned SLOT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(WORD_BITS - 1);

  logic              mclk_q;
  logic              mclk_edge;
  logic [BR_W-1:0]   cnt;
  logic [SLOT_W-1:0] slot;

  assign mclk_edge = mclk ^ mclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mclk_q <= 1'b0;
      cnt    <= '0;
      sck    <= 1'b0;
      ws     <= 1'b0;
      slot   <= '0;
    end else begin
      mclk_q <= mclk;
      if (load) begin
        cnt  <= '0;
        sck  <= 1'b0;
        ws   <= 1'b0;
        slot <= '0;
      end else if (mclk_edge) begin
        if (cnt == ratio) begin
          cnt <= '0;
          sck <= ~sck;
          if (sck) begin
            if (slot == SLOT_LAST) begin
              slot <= '0;
              ws   <= ~ws;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ratio)
    else $error("bit counter beyond limit"); // R6

  AST_SCK_ON_MCLK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((sck != $past(sck)) && !$past(load)) |-> $past(mclk_edge))
    else $error("sck moved without master clock edge"); // R6

  AST_WS_ON_SCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((ws != $past(ws)) && !$past(load)) |-> $fell(sck))
    else $error("ws moved outside sck fall"); // R7

endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clkgen_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BR_W      = 6,
  parameter int unsigned WORD_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_tick,
  input  logic              pll_tick,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [1:0]        mclk_i,
  input  logic [1:0]        sck_i,
  input  logic [1:0]        ws_i,
  output logic [1:0]        mclk_o,
  output logic [1:0]        mclk_oe,
  output logic [1:0]        sck_o,
  output logic [1:0]        sck_oe,
  output logic [1:0]        ws_o,
  output logic [1:0]        ws_oe,
  output logic [1:0]        sck_int,
  output logic [1:0]        ws_int
);

  localparam int unsigned FRAC_W = DATA_W / 2;

  logic [1:0]             slave;
  mode_t [1:0]            mode;
  logic [1:0][DATA_W-1:0] rate;
  logic [1:0][BR_W-1:0]   brate;
  logic                   src_pll;
  logic [1:0]             rate_load;
  logic [1:0]             bits_load;
  logic                   src_tick;
  logic [1:0]             div_mclk;
  logic [1:0]             sel_mclk;
  logic [1:0]             gen_sck;
  logic [1:0]             gen_ws;
  logic [1:0]             mst_sck;
  logic [1:0]             mst_ws;

  i2s_clk_regs #(.DATA_W(DATA_W), .BR_W(BR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .slave     (slave),
    .mode      (mode),
    .rate      (rate),
    .brate     (brate),
    .src_pll   (src_pll),
    .rate_load (rate_load),
    .bits_load (bits_load)
  );

  assign src_tick = src_pll ? pll_tick : pclk_tick;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam int O = 1 - d;

    i2s_frac_div #(.FRAC_W(FRAC_W)) u_frac (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (src_tick),
      .load  (rate_load[d]),
      .num   (rate[d][DATA_W-1:FRAC_W]),
      .den   (rate[d][FRAC_W-1:0]),
      .mclk  (div_mclk[d])
    );

    always_comb begin
      unique case (mode[d].msrc)
        MSRC_OWN:   sel_mclk[d] = div_mclk[d];
        MSRC_OTHER: sel_mclk[d] = div_mclk[O];
        MSRC_PIN:   sel_mclk[d] = mclk_i[d];
        default:    sel_mclk[d] = 1'b0;
      endcase
    end

    i2s_bit_div #(.BR_W(BR_W), .WORD_BITS(WORD_BITS)) u_bits (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (bits_load[d]),
      .mclk  (sel_mclk[d]),
      .ratio (brate[d]),
      .sck   (gen_sck[d]),
      .ws    (gen_ws[d])
    );

    assign mst_sck[d] = mode[d].share ? gen_sck[O] : gen_sck[d];
    assign mst_ws[d]  = mode[d].share ? gen_ws[O]  : gen_ws[d];

    assign mclk_o[d]  = sel_mclk[d];
    assign mclk_oe[d] = mode[d].mclk_oe;
    assign sck_o[d]   = mst_sck[d];
    assign ws_o[d]    = mst_ws[d];
    assign sck_oe[d]  = ~slave[d];
    assign ws_oe[d]   = ~slave[d];
    assign sck_int[d] = slave[d] ? sck_i[d] : mst_sck[d];
    assign ws_int[d]  = slave[d] ? ws_i[d]  : mst_ws[d];

    AST_MCLK_OFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[d].msrc == MSRC_OFF) |-> !mclk_o[d])
      else $error("master clock active with source code 11"); // R5

    AST_SHARE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave[d] && mode[d].share && !mode[O].share) |->
        ((sck_int[d] == sck_o[O]) && (ws_int[d] == ws_o[O])))
      else $error("borrowed clock pair diverged"); // R8
  end

endmodule

// File: tb/i2s_clkgen_bench.sv
module i2s_clkgen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pclk_tick = 1'b1;
  logic       pll_tick = 1'b0;
  logic       pll_run = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] mclk_i = '0, sck_i = '0, ws_i = '0;
  logic [1:0] mclk_o, mclk_oe, sck_o, sck_oe, ws_o, ws_oe, sck_int, ws_int;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  always @(negedge clk) pll_tick <= pll_run ? ~pll_tick : 1'b0;

  i2s_clkgen u_i2s_clkgen (
    .clk(clk), .rst_n(rst_n), .pclk_tick(pclk_tick), .pll_tick(pll_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mclk_i(mclk_i), .sck_i(sck_i), .ws_i(ws_i),
    .mclk_o(mclk_o), .mclk_oe(mclk_oe), .sck_o(sck_o), .sck_oe(sck_oe),
    .ws_o(ws_o), .ws_oe(ws_oe), .sck_int(sck_int), .ws_int(ws_int)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int pick(input int which);
    case (which)
      0: return int'(mclk_o[0]);
      1: return int'(sck_o[0]);
      2: return int'(ws_o[0]);
      3: return int'(mclk_o[1]);
      default: return int'(sck_o[1]);
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // half period in cycles between two consecutive toggles; -1 if none
  task automatic measure(input int which, output int half);
    int prev;
    int n;
    half = -1;
    prev = pick(which);
    n = 0;
    while (pick(which) == prev && n < 2000) begin step(); n++; end
    if (n >= 2000) return;
    prev = pick(which);
    n = 0;
    while (pick(which) == prev && n < 2000) begin step(); n++; end
    if (n < 2000) half = n;
  endtask

  task automatic t_reset();
    chk("R1 mclk_o", int'(mclk_o), 0);
    chk("R1 mclk_oe", int'(mclk_oe), 0);
    chk("R1 sck_oe", int'(sck_oe), 0);
    chk("R1 ws_oe", int'(ws_oe), 0);
  endtask

  task automatic t_frac();
    int h;
    int cnt;
    int prev;
    wr(4'd4, 16'h0104);
    measure(0, h);
    chk("R2 half period X=1 Y=4", h, 4);
    wr(4'd4, 16'h0308);
    cnt = 0;
    prev = pick(0);
    for (int i = 0; i < 64; i++) begin
      step();
      if (pick(0) != prev) cnt++;
      prev = pick(0);
    end
    chk("R2 toggles over 64 ticks X=3 Y=8", cnt, 24);
    wr(4'd5, 16'h0102);
    measure(3, h);
    chk("R2 rx half period X=1 Y=2", h, 2);
  endtask

  task automatic t_invalid();
    int hi;
    wr(4'd4, 16'h0008);
    hi = 0;
    for (int i = 0; i < 60; i++) begin step(); hi += int'(mclk_o[0]); end
    chk("R3 X=0 held low", hi, 0);
    wr(4'd4, 16'h0905);
    hi = 0;
    for (int i = 0; i < 60; i++) begin step(); hi += int'(mclk_o[0]); end
    chk("R3 X>Y held low", hi, 0);
  endtask

  task automatic t_source();
    int h;
    wr(4'd4, 16'h0102);
    measure(0, h);
    chk("R4 pclk source half", h, 2);
    pll_run = 1'b1;
    wr(4'd8, 16'h0001);
    measure(0, h);
    chk("R4 pll source half", h, 4);
    wr(4'd8, 16'h0000);
    pll_run = 1'b0;
  endtask

  task automatic t_mclk_mux();
    int h;
    int hi;
    int mis;
    wr(4'd4, 16'h0104);
    wr(4'd5, 16'h0000);
    wr(4'd3, 16'h0001);
    measure(3, h);
    chk("R5 code 01 borrows other divider", h, 4);
    wr(4'd3, 16'h0002);
    mis = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      mclk_i[1] = i[0];
      #1;
      if (mclk_o[1] != i[0]) mis++;
    end
    chk("R5 code 10 follows pin", mis, 0);
    wr(4'd3, 16'h0003);
    mclk_i[1] = 1'b1;
    wr(4'd5, 16'h0101);
    hi = 0;
    for (int i = 0; i < 40; i++) begin step(); hi += int'(mclk_o[1]); end
    chk("R5 code 11 held low", hi, 0);
    mclk_i[1] = 1'b0;
    wr(4'd3, 16'h0000);
  endtask

  task automatic t_bitrate();
    int h;
    wr(4'd0, 16'h0000);
    wr(4'd4, 16'h0101);
    wr(4'd6, 16'h0003);
    measure(1, h);
    chk("R6 N=3 sck half", h, 4);
    wr(4'd6, 16'h0000);
    measure(1, h);
    chk("R6 N=0 sck half", h, 1);
    wr(4'd6, 16'h003F);
    measure(1, h);
    chk("R6 N=63 sck half", h, 64);
  endtask

  task automatic t_ws();
    int h;
    wr(4'd6, 16'h0003);
    measure(2, h);
    chk("R7 ws half period 16 sck", h, 128);
  endtask

  task automatic t_share();
    int mis;
    int tog;
    int prev;
    wr(4'd1, 16'h0000);
    wr(4'd5, 16'h0000);
    wr(4'd3, 16'h0004);
    mis = 0;
    tog = 0;
    prev = int'(sck_o[1]);
    for (int i = 0; i < 60; i++) begin
      step();
      if (sck_o[1] != sck_o[0] || ws_o[1] != ws_o[0] || sck_int[1] != sck_o[0]) mis++;
      if (int'(sck_o[1]) != prev) tog++;
      prev = int'(sck_o[1]);
    end
    chk("R8 shared pair mismatches", mis, 0);
    chk("R8 shared sck moving", int'(tog > 0), 1);
    wr(4'd3, 16'h0000);
  endtask

  task automatic t_slave();
    chk("R9 master sck_oe", int'(sck_oe[0]), 1);
    chk("R9 master ws_oe", int'(ws_oe[0]), 1);
    wr(4'd0, 16'h0020);
    chk("R9 slave sck_oe", int'(sck_oe[0]), 0);
    chk("R9 slave ws_oe", int'(ws_oe[0]), 0);
    sck_i[0] = 1'b1; ws_i[0] = 1'b0;
    #1;
    chk("R9 slave sck_int from pin", int'(sck_int[0]), 1);
    chk("R9 slave ws_int from pin", int'(ws_int[0]), 0);
    sck_i[0] = 1'b0; ws_i[0] = 1'b1;
    #1;
    chk("R9 slave sck_int low", int'(sck_int[0]), 0);
    chk("R9 slave ws_int high", int'(ws_int[0]), 1);
    ws_i[0] = 1'b0;
    wr(4'd0, 16'h0000);
  endtask

  task automatic t_mclk_oe();
    wr(4'd2, 16'h0008);
    chk("R10 mclk_oe set", int'(mclk_oe[0]), 1);
    chk("R10 other mclk_oe clear", int'(mclk_oe[1]), 0);
    wr(4'd2, 16'h0000);
    chk("R10 mclk_oe clear", int'(mclk_oe[0]), 0);
  endtask

  task automatic t_reload();
    int c;
    wr(4'd4, 16'h0101);
    repeat (3) step();
    wr(4'd4, 16'h0105);
    chk("R11 mclk cleared by rate write", int'(mclk_o[0]), 0);
    c = 0;
    for (int i = 1; i <= 20; i++) begin
      step();
      if (mclk_o[0] && c == 0) c = i;
    end
    chk("R11 first rise after reload", c, 5);
    wr(4'd4, 16'h0101);
    repeat (40) step();
    wr(4'd6, 16'h0001);
    chk("R11 sck cleared by bit-rate write", int'(sck_o[0]), 0);
    chk("R11 ws cleared by bit-rate write", int'(ws_o[0]), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frac();
    t_invalid();
    t_source();
    t_mclk_mux();
    t_bitrate();
    t_ws();
    t_share();
    t_slave();
    t_mclk_oe();
    t_reload();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule